// File: doc/BRIEF.md
# Serial programming host sequencer

This block is the host-side engine that puts a target microcontroller into its serial programming mode and then carries out programming operations over four target pins: a serial clock, a serial data output, a serial data input and the target's reset line. A host presents one operation at a time on a valid/ready command port. The block turns each operation into one or more four-byte serial frames and sends them most significant bit first. The target samples on the rising clock edge, and data changes while the clock is low.

Entering programming mode works as follows. The block keeps the serial clock low and pulses the reset line high. It waits the settling time and then sends the four-byte enable frame. While the third byte shifts out, it checks that the second byte (0x53) comes back from the target. Each failed attempt causes a fresh reset pulse and a new enable frame. After a set number of failures the block reports loss of sync. Once in sync, the host can load flash words, commit flash pages, write EEPROM bytes, erase, write fuses and verify locations. After each write the block either waits a minimum delay counted in host clock cycles or polls the target's busy flag. A final operation drives reset high to release the target.

Top module: `prog_link_seq`

## Requirements
- R1: The ENTER operation (cmd_op 0) drives tgt_reset high for at least PULSE_CYC cycles. tgt_sck stays low whenever tgt_reset is high.
- R2: After the reset pulse ends, the first tgt_sck rise comes no sooner than CLK_HZ/50 cycles (20 ms).
- R3: The enable frame is the bytes {OPC_EN=0xA5, 0x53, 0x00, 0x00}. All four bytes are always sent, MSB first. tgt_mosi changes only while tgt_sck is low, and tgt_miso is sampled on the rising edge.
- R4: If the third received byte of the enable frame equals 0x53, sync_ok is set. Otherwise the reset pulse and the enable frame are repeated.
- R5: After MAX_TRY failed enable attempts, sync_fail is set and no further frame is sent. sync_ok and sync_fail are never both set.
- R6: LOAD (cmd_op 1) sends {OPC_LDL=0x41, 0x00, addr[4:0], data[7:0]} and then {OPC_LDH=0x49, 0x00, addr[4:0], data[15:8]}, the low byte first.
- R7: PAGE (cmd_op 2) sends {OPC_WPG=0x4D, addr[10:5] placed at word-address bits 10:5 of a 16-bit field, 0x00}.
- R8: When poll_mode=0, no frame starts sooner than the minimum delay after a write frame ends. The delays are CLK_HZ*9/2000 cycles after PAGE and FUSE, and CLK_HZ/250 cycles after EEWR and ERASE. EEWR (cmd_op 3) sends {OPC_WEE=0xC1, 0x00, addr[7:0], data[7:0]}. ERASE (cmd_op 4) sends {OPC_ERA=0xAE, 0, 0, 0}. FUSE (cmd_op 5) sends {OPC_FUS=0xAD, 0, 0, data[7:0]}.
- R9: When poll_mode=1, each write frame is followed by poll frames {OPC_POL=0xF1, 0, 0, 0}. Polling repeats while bit 0 of the fourth received byte is 1, and there is no fixed wait.
- R10: When skip_ff=1, a data byte of 0xFF causes its LOAD half-frame or its EEWR frame to be left out.
- R11: VERIFY (cmd_op 6) sends {OPC_RD=0x21, addr[15:0], 0x00} and raises rd_valid for one cycle. rd_data then holds the fourth received byte, and rd_match is 1 when that byte equals data[7:0].
- R12: LEAVE (cmd_op 7) drives tgt_reset high and keeps it there with no frame.
- R13: After reset, cmd_ready=1, tgt_reset=1, tgt_sck=0, and sync_ok, sync_fail and rd_valid are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Operation offered |
| cmd_ready | output | 1 | Sequencer idle; operation taken when valid |
| cmd_op | input | 3 | Operation code (0 ENTER .. 7 LEAVE) |
| cmd_addr | input | 11 | Word or byte address |
| cmd_data | input | 16 | Data word, or byte in [7:0] |
| skip_ff | input | 1 | Target freshly erased: skip 0xFF bytes |
| poll_mode | input | 1 | Poll busy flag instead of fixed delay |
| rd_valid | output | 1 | Verify result strobe |
| rd_data | output | 8 | Byte read back |
| rd_match | output | 1 | Read byte equals expected |
| sync_ok | output | 1 | Enable echo seen |
| sync_fail | output | 1 | Retry limit reached |
| tgt_sck | output | 1 | Serial clock to target |
| tgt_mosi | output | 1 | Serial data to target |
| tgt_miso | input | 1 | Serial data from target |
| tgt_reset | output | 1 | Target reset line level |

## Verification
The hardest case to reach from the ports is the resynchronisation path. An echo mismatch occurs only on a real link error, and the retry limit requires several mismatches in a row. The bench's behavioural target model has a counter of enable frames to answer with a wrong echo. Setting that counter to one exercises a single retry, and setting it to MAX_TRY drives the block into sync failure. In both cases the bench measures every reset pulse width and settling gap along the way. The busy-poll loop is reached the same way: the model answers a chosen number of poll frames as busy.

// File: rtl/prog_seq_pkg.sv
// Shared constants and types for the serial programming sequencer.
// Opcode values are placeholders for the target's command set; only
// the sync byte is fixed by the link's resynchronisation rule.
package prog_seq_pkg;
    localparam int LO_BITS = 5;                 // word-in-page address bits
    localparam int HI_BITS = 6;                 // page number bits
    localparam int AW      = LO_BITS + HI_BITS;

    localparam logic [7:0] SYNC_BYTE = 8'h53;
    localparam logic [7:0] OPC_EN    = 8'hA5;
    localparam logic [7:0] OPC_LDL   = 8'h41;
    localparam logic [7:0] OPC_LDH   = 8'h49;
    localparam logic [7:0] OPC_WPG   = 8'h4D;
    localparam logic [7:0] OPC_WEE   = 8'hC1;
    localparam logic [7:0] OPC_ERA   = 8'hAE;
    localparam logic [7:0] OPC_FUS   = 8'hAD;
    localparam logic [7:0] OPC_RD    = 8'h21;
    localparam logic [7:0] OPC_POL   = 8'hF1;

    typedef enum logic [2:0] {
        OP_ENTER, OP_LOAD, OP_PAGE, OP_EEWR, OP_ERASE, OP_FUSE, OP_VERIFY, OP_LEAVE
    } op_t;

    typedef enum logic [2:0] {
        K_EN, K_LDL, K_LDH, K_WRITE, K_READ, K_POLL
    } kind_t;
endpackage

// File: rtl/prog_wait.sv
// Down-counting delay timer.
// Assumes: load is a single-cycle strobe; idle is low in the load cycle
// so a caller that loads and then polls idle never sees a stale zero.
module prog_wait #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] cycles,
    output logic         idle
);
    logic [W-1:0] cnt;

    // load a new count or step the running count toward zero
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= cycles;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign idle = (cnt == '0) && !load;
endmodule

// File: rtl/prog_shift.sv
// One-byte serial shifter, clock idle low, MSB first.
// Data out changes only on the falling clock edge; the input is sampled
// as the clock rises. Each half period lasts HALF host cycles.
// Assumes: start is only raised while the shifter is idle.
module prog_shift #(
    parameter int HALF = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;
    logic [2:0]    bitn;
    logic [7:0]    sh;
    logic          active;
    logic          phase;

    // half-period timing, bit shifting and input capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0; bitn <= '0; sh <= '0; active <= 1'b0;
            phase <= 1'b0; done <= 1'b0; rx <= '0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active <= 1'b1; sh <= tx; bitn <= '0;
                    phase <= 1'b0; cnt <= '0;
                end
            end else if (cnt == CW'(HALF - 1)) begin
                cnt <= '0;
                if (!phase) begin
                    phase <= 1'b1;
                    rx    <= {rx[6:0], miso};
                end else begin
                    phase <= 1'b0;
                    sh    <= {sh[6:0], 1'b0};
                    if (bitn == 3'd7) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        bitn <= bitn + 1'b1;
                    end
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign sck  = phase;
    assign mosi = sh[7];

    // R3
    mosi_stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi));
endmodule

// File: rtl/prog_link_seq.sv
// Serial programming host sequencer: reset pulse, enable with echo
// check and retry, page loading, page and byte writes with a fixed delay
// or busy polling, verify, and release of reset.
// Assumes: the host issues ENTER before the other operations, and the
// target answers MSB first with its output changed after falling edges.
module prog_link_seq
    import prog_seq_pkg::*;
#(
    parameter int CLK_HZ    = 125_000_000,
    parameter int HALF      = 4,
    parameter int PULSE_CYC = 8,
    parameter int MAX_TRY   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [2:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic [15:0]   cmd_data,
    input  logic          skip_ff,
    input  logic          poll_mode,
    output logic          rd_valid,
    output logic [7:0]    rd_data,
    output logic          rd_match,
    output logic          sync_ok,
    output logic          sync_fail,
    output logic          tgt_sck,
    output logic          tgt_mosi,
    input  logic          tgt_miso,
    output logic          tgt_reset
);
    localparam int T_SET   = CLK_HZ / 50;
    localparam int T_FLASH = CLK_HZ * 9 / 2000;
    localparam int T_EE    = CLK_HZ / 250;
    localparam int TW      = $clog2(T_SET + 1);
    localparam int TRW     = $clog2(MAX_TRY + 1);

    typedef enum logic [2:0] {S_IDLE, S_PULSE, S_SETTLE, S_XFER, S_CHECK, S_WAIT} st_t;

    st_t            st;
    kind_t          kind;
    logic [31:0]    frame;
    logic [15:0]    rxw;
    logic [1:0]     bidx;
    logic           launch;
    logic [TRW-1:0] tries;
    logic [TW-1:0]  wait_cyc;
    logic [TW-1:0]  t_cyc;
    logic           t_load, t_idle;
    logic [AW-1:0]  addr;
    logic [15:0]    data;
    logic           sh_done;
    logic [7:0]     sh_rx;
    op_t            op;

    assign op        = op_t'(cmd_op);
    assign cmd_ready = (st == S_IDLE);

    prog_wait #(.W(TW)) u_wait (
        .clk(clk), .rst_n(rst_n), .load(t_load), .cycles(t_cyc), .idle(t_idle)
    );

    prog_shift #(.HALF(HALF)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(launch), .tx(frame[31:24]),
        .miso(tgt_miso), .sck(tgt_sck), .mosi(tgt_mosi), .done(sh_done), .rx(sh_rx)
    );

    // sequencing of operations, frames, retries and delays
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE; kind <= K_EN; frame <= '0; rxw <= '0; bidx <= '0;
            launch <= 1'b0; tries <= '0; wait_cyc <= '0; t_cyc <= '0;
            t_load <= 1'b0; addr <= '0; data <= '0; rd_valid <= 1'b0;
            rd_data <= '0; rd_match <= 1'b0; sync_ok <= 1'b0;
            sync_fail <= 1'b0; tgt_reset <= 1'b1;
        end else begin
            launch   <= 1'b0;
            t_load   <= 1'b0;
            rd_valid <= 1'b0;
            case (st)
                S_IDLE: if (cmd_valid) begin
                    addr <= cmd_addr;
                    data <= cmd_data;
                    bidx <= '0;
                    case (op)
                        OP_ENTER: begin
                            sync_ok <= 1'b0; sync_fail <= 1'b0; tries <= '0;
                            tgt_reset <= 1'b1; t_load <= 1'b1;
                            t_cyc <= TW'(PULSE_CYC); st <= S_PULSE;
                        end
                        OP_LOAD: begin
                            if (!(skip_ff && cmd_data[7:0] == 8'hFF)) begin
                                kind <= K_LDL; launch <= 1'b1; st <= S_XFER;
                                frame <= {OPC_LDL, 8'h00, 8'(cmd_addr[LO_BITS-1:0]), cmd_data[7:0]};
                            end else if (!(skip_ff && cmd_data[15:8] == 8'hFF)) begin
                                kind <= K_LDH; launch <= 1'b1; st <= S_XFER;
                                frame <= {OPC_LDH, 8'h00, 8'(cmd_addr[LO_BITS-1:0]), cmd_data[15:8]};
                            end
                        end
                        OP_PAGE: begin
                            kind <= K_WRITE; launch <= 1'b1; st <= S_XFER;
                            wait_cyc <= TW'(T_FLASH);
                            frame <= {OPC_WPG, 16'({cmd_addr[AW-1:LO_BITS], {LO_BITS{1'b0}}}), 8'h00};
                        end
                        OP_EEWR: if (!(skip_ff && cmd_data[7:0] == 8'hFF)) begin
                            kind <= K_WRITE; launch <= 1'b1; st <= S_XFER;
                            wait_cyc <= TW'(T_EE);
                            frame <= {OPC_WEE, 8'h00, cmd_addr[7:0], cmd_data[7:0]};
                        end
                        OP_ERASE: begin
                            kind <= K_WRITE; launch <= 1'b1; st <= S_XFER;
                            wait_cyc <= TW'(T_EE);
                            frame <= {OPC_ERA, 24'h0};
                        end
                        OP_FUSE: begin
                            kind <= K_WRITE; launch <= 1'b1; st <= S_XFER;
                            wait_cyc <= TW'(T_FLASH);
                            frame <= {OPC_FUS, 16'h0, cmd_data[7:0]};
                        end
                        OP_VERIFY: begin
                            kind <= K_READ; launch <= 1'b1; st <= S_XFER;
                            frame <= {OPC_RD, 16'(cmd_addr), 8'h00};
                        end
                        default: tgt_reset <= 1'b1;   // OP_LEAVE
                    endcase
                end
                S_PULSE: if (t_idle) begin
                    tgt_reset <= 1'b0; t_load <= 1'b1;
                    t_cyc <= TW'(T_SET); st <= S_SETTLE;
                end
                S_SETTLE: if (t_idle) begin
                    kind <= K_EN; frame <= {OPC_EN, SYNC_BYTE, 16'h0};
                    bidx <= '0; launch <= 1'b1; st <= S_XFER;
                end
                S_XFER: if (sh_done) begin
                    rxw   <= {rxw[7:0], sh_rx};
                    frame <= {frame[23:0], 8'h00};
                    if (bidx == 2'd3) st <= S_CHECK;
                    else begin bidx <= bidx + 1'b1; launch <= 1'b1; end
                end
                S_CHECK: begin
                    bidx <= '0;
                    st   <= S_IDLE;
                    case (kind)
                        K_EN: if (rxw[15:8] == SYNC_BYTE) sync_ok <= 1'b1;
                              else if (tries == TRW'(MAX_TRY - 1)) sync_fail <= 1'b1;
                              else begin
                                  tries <= tries + 1'b1; tgt_reset <= 1'b1;
                                  t_load <= 1'b1; t_cyc <= TW'(PULSE_CYC); st <= S_PULSE;
                              end
                        K_LDL: if (!(skip_ff && data[15:8] == 8'hFF)) begin
                            kind <= K_LDH; launch <= 1'b1; st <= S_XFER;
                            frame <= {OPC_LDH, 8'h00, 8'(addr[LO_BITS-1:0]), data[15:8]};
                        end
                        K_WRITE, K_POLL:
                            if (poll_mode && (kind == K_WRITE || rxw[0])) begin
                                kind <= K_POLL; launch <= 1'b1; st <= S_XFER;
                                frame <= {OPC_POL, 24'h0};
                            end else if (kind == K_WRITE) begin
                                t_load <= 1'b1; t_cyc <= wait_cyc; st <= S_WAIT;
                            end
                        K_READ: begin
                            rd_valid <= 1'b1; rd_data <= rxw[7:0];
                            rd_match <= (rxw[7:0] == data[7:0]);
                        end
                        default: ;
                    endcase
                end
                S_WAIT: if (t_idle) st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    // R1
    sck_low_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_reset |-> !tgt_sck);
    // R8
    quiet_during_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WAIT) |-> !tgt_sck);
    // R5
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sync_ok && sync_fail));
    // R11
    rd_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
endmodule

// File: tb/prog_link_seq_test.sv
// Bench: behavioural target model plus per-clock timing monitor.
module prog_link_seq_test;
    import prog_seq_pkg::*;

    localparam int CLK_HZ = 200_000, HALF = 2, PULSE_CYC = 6, MAX_TRY = 3;
    localparam int T_SET = 4000, T_FLASH = 900, T_EE = 800;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0, skip_ff = 1'b0, poll_mode = 1'b0, tgt_miso = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [10:0] cmd_addr = '0;
    logic [15:0] cmd_data = '0;
    logic cmd_ready, rd_valid, rd_match, sync_ok, sync_fail, tgt_sck, tgt_mosi, tgt_reset;
    logic [7:0] rd_data;

    prog_link_seq #(.CLK_HZ(CLK_HZ), .HALF(HALF), .PULSE_CYC(PULSE_CYC), .MAX_TRY(MAX_TRY)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .skip_ff(skip_ff),
        .poll_mode(poll_mode), .rd_valid(rd_valid), .rd_data(rd_data), .rd_match(rd_match),
        .sync_ok(sync_ok), .sync_fail(sync_fail), .tgt_sck(tgt_sck), .tgt_mosi(tgt_mosi),
        .tgt_miso(tgt_miso), .tgt_reset(tgt_reset)
    );

    always #4 clk = ~clk;   // 125 MHz

    int checks = 0, fails = 0, cyc = 0;
    always @(posedge clk) cyc++;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- target model ----------------
    logic [31:0] got_q[$];
    logic [31:0] exp_q[$];
    logic [7:0]  cur[4];
    logic [7:0]  rsh = '0, obyte = '0, reply4 = '0;
    int bitc = 0, bytec = 0, bad_echo = 0, busy_polls = 0;
    int gap_pend = 0, mark_end = 0;

    always @(posedge tgt_reset) begin bitc = 0; bytec = 0; end

    always @(posedge tgt_sck) begin
        rsh = {rsh[6:0], tgt_mosi};
        bitc++;
        if (bitc == 8) begin
            cur[bytec] = rsh;
            bitc = 0;
            if (bytec == 3) begin
                got_q.push_back({cur[0], cur[1], cur[2], cur[3]});
                if (cur[0] == OPC_EN && bad_echo > 0) bad_echo--;
                if (cur[0] == OPC_POL && busy_polls > 0) busy_polls--;
                mark_end = 1;
                gap_pend = 0;
                if (!poll_mode) begin
                    if (cur[0] == OPC_WPG || cur[0] == OPC_FUS) gap_pend = T_FLASH;
                    if (cur[0] == OPC_WEE || cur[0] == OPC_ERA) gap_pend = T_EE;
                end
                bytec = 0;
            end else bytec++;
        end
    end

    always @(negedge tgt_sck) begin
        if (bitc == 0) begin
            case (bytec)
                2: obyte = (cur[0] == OPC_EN && bad_echo == 0) ? cur[1] : 8'h00;
                3: obyte = (cur[0] == OPC_RD) ? reply4 :
                           (cur[0] == OPC_POL) ? ((busy_polls > 0) ? 8'h01 : 8'h00) : 8'h00;
                default: obyte = 8'h00;
            endcase
        end
        tgt_miso = obyte[7 - bitc];
    end

    // ---------------- per-clock monitor ----------------
    logic p_sck = 1'b0, p_rst = 1'b1;
    int hi_cnt = 0, rst_fall = 0, settle_pend = 0, end_fall = 0, gap_req = 0;
    int pulses = 0, rd_seen = 0;
    logic [7:0] rd_d = '0;
    logic rd_m = 1'b0;

    always @(negedge clk) if (rst_n) begin
        check(!(tgt_reset && tgt_sck), "R1 sck low in reset", tgt_sck, 0);
        if (tgt_reset) hi_cnt++;
        if (!tgt_reset && p_rst) begin
            check(hi_cnt >= PULSE_CYC, "R1 pulse width", hi_cnt, PULSE_CYC);
            pulses++; rst_fall = cyc; settle_pend = 1; hi_cnt = 0;
        end
        if (tgt_sck && !p_sck) begin
            if (settle_pend) begin
                check(cyc - rst_fall >= T_SET, "R2 settle gap", cyc - rst_fall, T_SET);
                settle_pend = 0;
            end
            if (gap_req > 0) begin
                check(cyc - end_fall >= gap_req, "R8 write delay", cyc - end_fall, gap_req);
                gap_req = 0;
            end
        end
        if (!tgt_sck && p_sck && mark_end) begin
            end_fall = cyc; gap_req = gap_pend; mark_end = 0;
        end
        if (rd_valid) begin rd_seen++; rd_d = rd_data; rd_m = rd_match; end
        p_sck = tgt_sck; p_rst = tgt_reset;
    end

    // ---------------- stimulus ----------------
    int t_acc = 0, t_done = 0;

    task automatic issue(input logic [2:0] op, input logic [10:0] a, input logic [15:0] d);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_op = op; cmd_addr = a; cmd_data = d; cmd_valid = 1'b1;
        t_acc = cyc;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!cmd_ready) @(negedge clk);
        t_done = cyc;
    endtask

    task automatic cmp_frames(input string tag);
        check(got_q.size() == exp_q.size(), {tag, " frame count"}, got_q.size(), exp_q.size());
        for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
            check(got_q[i] == exp_q[i], {tag, " frame"}, got_q[i], exp_q[i]);
        got_q.delete();
        exp_q.delete();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        check(cmd_ready == 1 && tgt_reset == 1 && tgt_sck == 0, "R13 idle pins",
              {cmd_ready, tgt_reset, tgt_sck}, 3'b110);
        check(sync_ok == 0 && sync_fail == 0 && rd_valid == 0, "R13 flags",
              {sync_ok, sync_fail, rd_valid}, 0);

        // R3 R4: one bad echo then sync
        bad_echo = 1; pulses = 0;
        exp_q.push_back({OPC_EN, 8'h53, 16'h0});
        exp_q.push_back({OPC_EN, 8'h53, 16'h0});
        issue(3'd0, 11'h0, 16'h0);
        cmp_frames("R3 enable");
        check(sync_ok == 1 && sync_fail == 0, "R4 sync after retry", {sync_ok, sync_fail}, 2'b10);
        check(pulses == 2, "R4 reset pulses", pulses, 2);

        // R6 word load, low byte first
        exp_q.push_back({OPC_LDL, 8'h00, 8'h13, 8'h34});
        exp_q.push_back({OPC_LDH, 8'h00, 8'h13, 8'h12});
        issue(3'd1, 11'h4B3, 16'h1234);
        cmp_frames("R6 load");

        // R7 R8 writes with fixed delays
        exp_q.push_back({OPC_WPG, 8'h04, 8'hA0, 8'h00});
        issue(3'd2, 11'h4B3, 16'h0);
        cmp_frames("R7 page");
        check(t_done - t_acc >= T_FLASH, "R8 page busy time", t_done - t_acc, T_FLASH);
        exp_q.push_back({OPC_WEE, 8'h00, 8'h37, 8'h5C});
        issue(3'd3, 11'h037, 16'h005C);
        cmp_frames("R8 eeprom");
        exp_q.push_back({OPC_ERA, 24'h0});
        issue(3'd4, 11'h0, 16'h0);
        cmp_frames("R8 erase");
        exp_q.push_back({OPC_FUS, 16'h0, 8'h9E});
        issue(3'd5, 11'h0, 16'h009E);
        cmp_frames("R8 fuse");

        // R10 skip of 0xFF bytes
        skip_ff = 1'b1;
        exp_q.push_back({OPC_LDL, 8'h00, 8'h02, 8'h77});
        issue(3'd1, 11'h022, 16'hFF77);
        cmp_frames("R10 high skipped");
        exp_q.push_back({OPC_LDH, 8'h00, 8'h03, 8'h55});
        issue(3'd1, 11'h023, 16'h55FF);
        cmp_frames("R10 low skipped");
        issue(3'd1, 11'h024, 16'hFFFF);
        cmp_frames("R10 both skipped");
        issue(3'd3, 11'h010, 16'h00FF);
        cmp_frames("R10 eeprom skipped");
        skip_ff = 1'b0;
        exp_q.push_back({OPC_WEE, 8'h00, 8'h10, 8'hFF});
        issue(3'd3, 11'h010, 16'h00FF);
        cmp_frames("R10 not skipped");

        // R9 busy polling
        poll_mode = 1'b1; busy_polls = 3;
        exp_q.push_back({OPC_WPG, 8'h07, 8'hE0, 8'h00});
        for (int i = 0; i < 4; i++) exp_q.push_back({OPC_POL, 24'h0});
        issue(3'd2, 11'h7FF, 16'h0);
        cmp_frames("R9 poll");
        check(t_done - t_acc < T_FLASH, "R9 no fixed wait", t_done - t_acc, T_FLASH);
        poll_mode = 1'b0;

        // R11 verify
        reply4 = 8'hA7; rd_seen = 0;
        exp_q.push_back({OPC_RD, 8'h03, 8'h21, 8'h00});
        issue(3'd6, 11'h321, 16'h00A7);
        repeat (2) @(negedge clk);
        cmp_frames("R11 read");
        check(rd_seen == 1 && rd_d == 8'hA7 && rd_m == 1, "R11 match",
              {rd_seen[7:0], rd_d, 7'b0, rd_m}, {8'd1, 8'hA7, 8'h01});
        reply4 = 8'h3C; rd_seen = 0;
        exp_q.push_back({OPC_RD, 8'h00, 8'h05, 8'h00});
        issue(3'd6, 11'h005, 16'h00A7);
        repeat (2) @(negedge clk);
        cmp_frames("R11 read");
        check(rd_seen == 1 && rd_d == 8'h3C && rd_m == 0, "R11 mismatch",
              {rd_seen[7:0], rd_d, 7'b0, rd_m}, {8'd1, 8'h3C, 8'h00});

        // R12 release
        issue(3'd7, 11'h0, 16'h0);
        check(tgt_reset == 1, "R12 released", tgt_reset, 1);
        repeat (50) @(negedge clk);
        check(tgt_reset == 1 && tgt_sck == 0, "R12 held", {tgt_reset, tgt_sck}, 2'b10);
        cmp_frames("R12 no frame");

        // R5 retry limit
        bad_echo = MAX_TRY; pulses = 0;
        for (int i = 0; i < MAX_TRY; i++) exp_q.push_back({OPC_EN, 8'h53, 16'h0});
        issue(3'd0, 11'h0, 16'h0);
        repeat (100) @(negedge clk);
        cmp_frames("R5 enable attempts");
        check(sync_fail == 1 && sync_ok == 0, "R5 sync fail", {sync_ok, sync_fail}, 2'b01);
        check(pulses == MAX_TRY, "R5 reset pulses", pulses, MAX_TRY);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule